// File: doc/BRIEF.md
# Configurable External Interrupt Forwarder

This block takes a group of asynchronous external interrupt lines and turns each one into an active-high level request for a parent interrupt controller. Line `i` feeds output `i` only. Each line has its own trigger setting. One bit picks whether the line is level or edge sensitive. A second bit picks high/rising or low/falling. The detected condition is held in a per-line latch. A per-line mask holds the matching output low without stopping that latch. Software removes held edge requests by writing ones to a clear register.

Software reaches the configuration and status through a small 32-bit register bus. A write is taken on a clock edge when `bus_wr` is high. Read data is a combinational function of `bus_addr`. Every input goes through a two-flop synchroniser before polarity and edge detection. As a result, a change at an input reaches its latch on the third rising clock edge after it is applied.

Top module: `xirq_fwd`

## Requirements
- R1: Register byte offsets are: 0x00 mask, 0x04 polarity, 0x08 edge select, 0x0C raw status (read-only), 0x10 pending status (read-only), 0x14 clear (write-only, reads 0), 0x18 route storage and 0x1C soft storage. While reset is high and just after it, mask reads 0xFFFFFFFF, polarity, edge select, route and soft read 0, raw status reads 0 and every output is 0.
- R2: Each output bit equals its pending status bit, which is raw status AND NOT mask. Outputs are always active-high whatever the line's trigger type.
- R3: A mask bit of 1 forces its output and pending bit to 0, but the raw latch still captures conditions on that line. Clearing the mask bit then raises the output.
- R4: With edge select bit 0 (level mode), the raw bit follows the synchronised input qualified by polarity: 1 when the input equals the polarity bit (polarity 1 = active high, 0 = active low). It follows on the third rising clock edge after the input changes.
- R5: With edge select 1 and polarity 1, a rising input sets the raw bit. The bit stays set after the input falls, until it is cleared.
- R6: With edge select 1 and polarity 0, a falling input sets the raw bit, and a rising input does not.
- R7: Writing the clear register clears each latched edge request whose data bit is 1. Data bits of 0 leave their lines unchanged.
- R8: If an edge detection and a clear of the same line land on the same clock edge, the line stays set.
- R9: Writing 0xFFFFFFFF to clear and then to mask empties every edge-mode latch and drives every output low.
- R10: The route and soft registers are plain 32-bit read/write storage.
- R11: Writes to the raw and pending status offsets change no state.
- R12: Lines are independent: each input affects only its own raw bit and output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | NUM_LINES | Asynchronous external interrupt inputs |
| bus_wr | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_o | output | NUM_LINES | Active-high level requests to the parent controller |

## Verification
The bench builds the block with its default of 32 lines and two synchroniser stages. At that size every bit of every register maps to a line, so all-ones words and full-width mixed polarity patterns exercise the whole datapath at once. Keeping the default synchroniser depth fixes the three-edge input-to-latch latency. That fixed latency lets the bench line a clear write up exactly with an edge detection to probe the set-over-clear priority.

// File: rtl/xirq_fwd_pkg.sv
package xirq_fwd_pkg;

    localparam int WORD_W    = 32;
    localparam int REG_IDX_W = 3;
    localparam int ADDR_W    = REG_IDX_W + 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_MASK  = 3'd0,
        RG_POL   = 3'd1,
        RG_EDGE  = 3'd2,
        RG_RAW   = 3'd3,
        RG_PEND  = 3'd4,
        RG_CLR   = 3'd5,
        RG_ROUTE = 3'd6,
        RG_SOFT  = 3'd7
    } xirq_reg_e;

    typedef struct packed {
        word_t mask;
        word_t pol;
        word_t edge_sel;
    } xirq_cfg_t;

    function automatic xirq_reg_e word_sel(input logic [ADDR_W-1:0] byte_addr);
        return xirq_reg_e'(byte_addr[ADDR_W-1:2]);
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] smp,
    output logic [W-1:0] smp_prev
);
    localparam int CHAIN = STAGES + 1;

    logic [W-1:0] chain [CHAIN];

    for (genvar g = 0; g < CHAIN; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[g] <= '0;
            end else if (g == 0) begin
                chain[g] <= din;
            end else begin
                chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign smp      = chain[STAGES-1];
    assign smp_prev = chain[STAGES];

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] smp_prev,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] clr,
    output logic [W-1:0] latch
);
    logic [W-1:0] qual;
    logic [W-1:0] hit;
    logic [W-1:0] latch_d;

    always_comb begin
        qual    = ~(smp ^ pol);
        hit     = (pol & smp & ~smp_prev) | (~pol & ~smp & smp_prev);
        latch_d = (~edge_sel & qual) | (edge_sel & (hit | (latch & ~clr)));
    end

    always_ff @(posedge clk) begin
        if (rst) latch <= '0;
        else     latch <= latch_d;
    end

    // level lines track the qualified sample
    assert_level_track_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~$past(edge_sel) & (latch ^ $past(qual))) == '0));

    // edge lines hold until cleared
    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (rst)
        ((latch & ~clr & edge_sel) != '0) |=> (($past(latch & ~clr & edge_sel) & ~latch) == '0));

    // clear without a new edge empties the latch
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~hit & edge_sel) != '0) |=> (($past(clr & ~hit & edge_sel) & latch) == '0));

    // detection beats a simultaneous clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        ((hit & clr & edge_sel) != '0) |=> (($past(hit & clr & edge_sel) & ~latch) == '0));

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_fwd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  word_t             bus_wdata,
    input  logic [W-1:0]      raw,
    input  logic [W-1:0]      pend,
    output xirq_cfg_t         cfg,
    output logic [W-1:0]      clr,
    output word_t             bus_rdata
);
    xirq_reg_e    sel;
    logic [W-1:0] mask_q;
    logic [W-1:0] pol_q;
    logic [W-1:0] edge_q;
    word_t        route_q;
    word_t        soft_q;
    logic         unused_low;

    assign sel        = word_sel(bus_addr);
    assign unused_low = ^bus_addr[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            pol_q   <= '0;
            edge_q  <= '0;
            route_q <= '0;
            soft_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                RG_MASK:  mask_q  <= bus_wdata[W-1:0];
                RG_POL:   pol_q   <= bus_wdata[W-1:0];
                RG_EDGE:  edge_q  <= bus_wdata[W-1:0];
                RG_ROUTE: route_q <= bus_wdata;
                RG_SOFT:  soft_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign clr = (bus_wr && sel == RG_CLR) ? bus_wdata[W-1:0] : '0;

    always_comb begin
        cfg.mask     = word_t'(mask_q);
        cfg.pol      = word_t'(pol_q);
        cfg.edge_sel = word_t'(edge_q);
        case (sel)
            RG_MASK:  bus_rdata = word_t'(mask_q);
            RG_POL:   bus_rdata = word_t'(pol_q);
            RG_EDGE:  bus_rdata = word_t'(edge_q);
            RG_RAW:   bus_rdata = word_t'(raw);
            RG_PEND:  bus_rdata = word_t'(pend);
            RG_ROUTE: bus_rdata = route_q;
            RG_SOFT:  bus_rdata = soft_q;
            default:  bus_rdata = '0;
        endcase
    end

    assert_route_store_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == RG_ROUTE) |=> (route_q == $past(bus_wdata)));

    assert_mask_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == RG_MASK) |=> (mask_q == $past(bus_wdata[W-1:0])));

endmodule

// File: rtl/xirq_fwd.sv
module xirq_fwd
    import xirq_fwd_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] ext_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq_o
);
    xirq_cfg_t            cfg;
    logic [NUM_LINES-1:0] smp;
    logic [NUM_LINES-1:0] smp_prev;
    logic [NUM_LINES-1:0] clr;
    logic [NUM_LINES-1:0] raw;
    logic [NUM_LINES-1:0] pend;

    xirq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (ext_in),
        .smp      (smp),
        .smp_prev (smp_prev)
    );

    xirq_detect #(.W(NUM_LINES)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .smp      (smp),
        .smp_prev (smp_prev),
        .pol      (cfg.pol[NUM_LINES-1:0]),
        .edge_sel (cfg.edge_sel[NUM_LINES-1:0]),
        .clr      (clr),
        .latch    (raw)
    );

    assign pend  = raw & ~cfg.mask[NUM_LINES-1:0];
    assign irq_o = pend;

    xirq_regs #(.W(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .raw       (raw),
        .pend      (pend),
        .cfg       (cfg),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: tb/xirq_fwd_tb.sv
module xirq_fwd_tb;
    localparam int N = 32;
    localparam logic [4:0] A_MASK = 5'h00, A_POL = 5'h04, A_EDGE = 5'h08, A_RAW = 5'h0C,
                           A_PEND = 5'h10, A_CLR = 5'h14, A_ROUTE = 5'h18, A_SOFT = 5'h1C;
    // {polarity, input, expected raw} for level mode
    localparam logic [95:0] VECS [5] = '{
        {32'hFFFFFFFF, 32'h0000FFFF, 32'h0000FFFF},
        {32'h00000000, 32'h0000FFFF, 32'hFFFF0000},
        {32'hF0F0F0F0, 32'hFF00FF00, 32'hF00FF00F},
        {32'hA5A5A5A5, 32'h5A5A5A5A, 32'h00000000},
        {32'h12345678, 32'h12345678, 32'hFFFFFFFF}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  ext_in = '0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_o;
    int            n_chk = 0;
    int            n_fail = 0;
    logic [31:0]   v;

    always #2.5 clk = ~clk;

    xirq_fwd u_dut (
        .clk(clk), .rst(rst), .ext_in(ext_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset values
        step(3);
        rd(A_MASK, v);  check("R1 mask", v, 32'hFFFFFFFF);
        rd(A_POL, v);   check("R1 pol", v, 32'h0);
        rd(A_EDGE, v);  check("R1 edge", v, 32'h0);
        rd(A_RAW, v);   check("R1 raw", v, 32'h0);
        rd(A_ROUTE, v); check("R1 route", v, 32'h0);
        rd(A_SOFT, v);  check("R1 soft", v, 32'h0);
        check("R1 out", irq_o, 32'h0);
        @(negedge clk) rst = 1'b0;
        step(1);
        check("R1 out after reset", irq_o, 32'h0);
        wr(A_MASK, 32'h0);

        // R4 R12 R2: level mode table
        for (int i = 0; i < 5; i++) begin
            wr(A_POL, VECS[i][95:64]);
            ext_in = VECS[i][63:32];
            step(3);
            rd(A_RAW, v);  check("R4 R12 level raw", v, VECS[i][31:0]);
            rd(A_PEND, v); check("R2 pending", v, VECS[i][31:0]);
            check("R2 out", irq_o, VECS[i][31:0]);
        end

        // switch to edge mode and empty the latches
        ext_in = '0;
        wr(A_POL, 32'hFFFFFFFF);
        step(3);
        wr(A_EDGE, 32'hFFFFFFFF);
        wr(A_CLR, 32'hFFFFFFFF);
        rd(A_RAW, v); check("R7 raw empty", v, 32'h0);

        // R5: rising edge latches and holds
        ext_in[3] = 1'b1; step(3);
        rd(A_RAW, v); check("R5 rise latched", v, 32'h8);
        check("R5 out", irq_o, 32'h8);
        ext_in[3] = 1'b0; step(3);
        rd(A_RAW, v); check("R5 hold after fall", v, 32'h8);
        wr(A_CLR, 32'h0);
        rd(A_RAW, v); check("R7 zero write no effect", v, 32'h8);
        wr(A_CLR, 32'h8);
        rd(A_RAW, v); check("R7 clear bit", v, 32'h0);

        // R6: falling-edge line
        wr(A_POL, ~32'h20);
        ext_in[5] = 1'b1; step(3);
        rd(A_RAW, v); check("R6 rise ignored", v, 32'h0);
        ext_in[5] = 1'b0; step(3);
        rd(A_RAW, v); check("R6 fall latched", v, 32'h20);
        wr(A_CLR, 32'h20);

        // R3: masked line still latches
        wr(A_MASK, 32'hFFFFFFFF);
        ext_in[9] = 1'b1; step(3);
        rd(A_RAW, v);  check("R3 raw while masked", v, 32'h200);
        rd(A_PEND, v); check("R3 pending masked", v, 32'h0);
        check("R3 out masked", irq_o, 32'h0);
        wr(A_MASK, 32'h0);
        @(negedge clk);
        check("R3 out after unmask", irq_o, 32'h200);

        // R8: clear on the same edge as detection
        @(negedge clk) ext_in[12] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h1000;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        rd(A_RAW, v); check("R8 set wins", v, 32'h1200);
        wr(A_CLR, 32'h1200);
        rd(A_RAW, v); check("R7 clear two", v, 32'h0);

        // R9: clear all and mask all
        ext_in = '0; wr(A_POL, 32'hFFFFFFFF); step(3);
        wr(A_CLR, 32'hFFFFFFFF);
        ext_in = 32'hFFFF0000; step(3);
        rd(A_RAW, v); check("R9 setup raw", v, 32'hFFFF0000);
        wr(A_CLR, 32'hFFFFFFFF);
        wr(A_MASK, 32'hFFFFFFFF);
        rd(A_RAW, v); check("R9 raw cleared", v, 32'h0);
        check("R9 out low", irq_o, 32'h0);

        // R10: storage registers
        wr(A_ROUTE, 32'hDEADBEEF);
        wr(A_SOFT, 32'h13579BDF);
        rd(A_ROUTE, v); check("R10 route", v, 32'hDEADBEEF);
        rd(A_SOFT, v);  check("R10 soft", v, 32'h13579BDF);

        // R11: read-only offsets ignore writes
        wr(A_RAW, 32'hFFFFFFFF);
        wr(A_PEND, 32'hFFFFFFFF);
        rd(A_RAW, v);  check("R11 raw unchanged", v, 32'h0);
        rd(A_MASK, v); check("R11 mask unchanged", v, 32'hFFFFFFFF);
        rd(A_CLR, v);  check("R11 clear reads zero", v, 32'h0);
        check("R11 out", irq_o, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule